// File: doc/BRIEF.md
# Sleep and Wakeup Controller for a Vehicle-Network Link

This block controls the power states of a serial vehicle-network link controller. The CPU asks for sleep on one of two request lines. A configuration bit decides whether a plain wait request gives a light sleep or a deep sleep. In light sleep the clocks keep running and the block wakes on a completed received frame. In deep sleep the clocks are shut off, and the block wakes on bus activity, after which the clocks must restart and settle before normal work resumes.

On every wakeup the block records whether the frame that caused it can be trusted. It also raises the matching interrupt: a maskable, held interrupt after a light-sleep wakeup, or a one-cycle non-maskable pulse after a deep-sleep wakeup. The transmitter is held off whenever the block is not fully awake. A sleep request that arrives while a transmission is still running is refused and recorded in a sticky flag. Framing, arbitration, CRC and the bit coding on the bus are not part of this block; they reach it only as status inputs.

Top module: `wake_top`

## Requirements
- R1: A `waitReq` while awake with `waitToDeep` low and `txActive` low enters light sleep on the next clock edge. In light sleep `inLight`=1, `clkStop`=0 and `txEnable`=0.
- R2: A `stopReq`, or a `waitReq` with `waitToDeep` high, while awake and with `txActive` low enters deep sleep on the next edge. In deep sleep `inDeep`=1, `clkStop`=1, `txEnable`=0 and `clocksReady`=0. `stopReq` takes priority over `waitReq`.
- R3: In light sleep, a `frameDone` pulse returns the block to awake on the next edge and sets `wakeFrameValid`=1. The same edge sets `maskIrq`=1 only when `intEnable` is high.
- R4: In light sleep, edges on `rxLine` have no effect. The block stays in light sleep and `nmiPulse` stays 0.
- R5: In deep sleep, a rising edge on `rxLine` (0 is passive, 1 is active) wakes the block on the next edge. That edge drops `clkStop` and raises `nmiPulse` for exactly one cycle.
- R6: After a deep wakeup, `clocksReady` stays 0 and `txEnable` stays 0 for exactly N cycles after the waking edge, and then both return to 1. N is `stabCycles`; a value of 0 selects the default of 64.
- R7: On a deep wakeup, `wakeFrameValid` is 1 only if deep sleep was entered through `waitReq` (not `stopReq`), `eofSeen` was high at entry and `rxBusy` was low at entry. In every other case it is 0.
- R8: If `rxBusy` was high when deep sleep was entered, any edge on `rxLine`, rising or falling, wakes the block and gives `wakeFrameValid`=0. Otherwise a falling edge does not wake it.
- R9: A sleep request while `txActive` is high is refused. The block stays awake with `txEnable`=1, and `sleepRefused` becomes 1 and stays 1 until reset.
- R10: `maskIrq` stays high until `intClear` is pulsed. It drops on the edge after the pulse.
- R11: After reset the block is awake: `txEnable`=1, `clocksReady`=1, and `maskIrq`, `nmiPulse`, `wakeFrameValid`, `sleepRefused`, `inLight`, `inDeep` and `clkStop` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| waitReq | input | 1 | CPU wait request |
| stopReq | input | 1 | CPU stop request |
| waitToDeep | input | 1 | Send wait requests to deep sleep |
| intEnable | input | 1 | Enables the maskable wakeup interrupt |
| intClear | input | 1 | Pulse that clears the maskable interrupt |
| rxLine | input | 1 | Bus receive line, 1 is active |
| frameDone | input | 1 | Pulse: a frame was received without error |
| eofSeen | input | 1 | End-of-frame has been detected |
| rxBusy | input | 1 | A frame is being received |
| txActive | input | 1 | A transmission is in progress |
| stabCycles | input | CNT_W | Clock settle length in cycles, 0 selects default |
| txEnable | output | 1 | Transmitter may drive the bus |
| clkStop | output | 1 | Request to stop the internal clocks |
| clocksReady | output | 1 | Clocks are running and settled |
| inLight | output | 1 | Light sleep active |
| inDeep | output | 1 | Deep sleep active |
| maskIrq | output | 1 | Maskable wakeup interrupt, held |
| nmiPulse | output | 1 | Non-maskable wakeup pulse |
| wakeFrameValid | output | 1 | Frame that caused the last wakeup is trusted |
| sleepRefused | output | 1 | Sticky: a sleep request met an active transmission |

## Verification
The embedded assertions check the following on every cycle:
- each kind of request leads to its matching next state;
- a light-sleep frame always ends the sleep;
- the non-maskable pulse never lasts two cycles;
- `clocksReady` only rises at the end of the settle window;
- the maskable interrupt holds until it is cleared;
- a deep entry made during reception never flags its waking frame as valid.

Some behaviour can only be shown by the bench's scenarios:
- the full validity truth table across entry paths, end-of-frame and reception state;
- the exact settle length, both programmed and default;
- a falling edge being ignored unless reception was in progress;
- bus edges being ignored in light sleep.

// File: rtl/wake_pkg.sv
package wake_pkg;

  typedef enum logic [1:0] {
    S_AWAKE = 2'd0,
    S_LIGHT = 2'd1,
    S_DEEP  = 2'd2,
    S_STAB  = 2'd3
  } sleepState_t;

  // Strobes from control to datapath, one cycle each except stabActive
  typedef struct packed {
    logic enterDeep;   // deep sleep entered at this edge
    logic viaWait;     // qualifies enterDeep: entry came from a wait request
    logic wakeLight;   // light sleep ends at this edge
    logic wakeDeep;    // deep sleep ends, settle window starts
    logic stabActive;  // inside the settle window
    logic refuse;      // sleep request refused, transmission active
  } wakeStrobe_t;

endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        waitReq,
  input  logic        stopReq,
  input  logic        waitToDeep,
  input  logic        txActive,
  input  logic        frameDone,
  input  logic        wakeEdge,
  input  logic        stabDone,
  output wakeStrobe_t strobe,
  output sleepState_t state
);

  sleepState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_AWAKE: begin
        if (waitReq || stopReq) begin
          if (txActive) begin
            strobe.refuse = 1'b1;
          end else if (stopReq || waitToDeep) begin
            nextState        = S_DEEP;
            strobe.enterDeep = 1'b1;
            strobe.viaWait   = !stopReq;
          end else begin
            nextState = S_LIGHT;
          end
        end
      end
      S_LIGHT: begin
        if (frameDone) begin
          nextState        = S_AWAKE;
          strobe.wakeLight = 1'b1;
        end
      end
      S_DEEP: begin
        if (wakeEdge) begin
          nextState       = S_STAB;
          strobe.wakeDeep = 1'b1;
        end
      end
      S_STAB: begin
        strobe.stabActive = 1'b1;
        if (stabDone) nextState = S_AWAKE;
      end
      default: nextState = S_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_AWAKE;
    else       state <= nextState;
  end

  assert_refuse_stays_awake_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AWAKE && (waitReq || stopReq) && txActive) |=> state == S_AWAKE);

  assert_stop_goes_deep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AWAKE && stopReq && !txActive) |=> state == S_DEEP);

  assert_light_entry_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AWAKE && waitReq && !stopReq && !waitToDeep && !txActive) |=> state == S_LIGHT);

  assert_frame_ends_light_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LIGHT && frameDone) |=> state == S_AWAKE);

endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int STAB_DEFAULT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  wakeStrobe_t      strobe,
  input  logic             rxLine,
  input  logic             eofSeen,
  input  logic             rxBusy,
  input  logic             intEnable,
  input  logic             intClear,
  input  logic [CNT_W-1:0] stabCycles,
  output logic             wakeEdge,
  output logic             stabDone,
  output logic             clocksReady,
  output logic             maskIrq,
  output logic             nmiPulse,
  output logic             wakeFrameValid,
  output logic             sleepRefused
);

  localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(STAB_DEFAULT);

  logic             rxPrev;
  logic             viaWaitQ, eofQ, busyQ;
  logic [CNT_W-1:0] stabCnt;
  logic [CNT_W-1:0] stabLen;

  // Edge detection on the receive line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b0;
    else       rxPrev <= rxLine;
  end

  // Conditions captured when deep sleep starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      viaWaitQ <= 1'b0;
      eofQ     <= 1'b0;
      busyQ    <= 1'b0;
    end else if (strobe.enterDeep) begin
      viaWaitQ <= strobe.viaWait;
      eofQ     <= eofSeen;
      busyQ    <= rxBusy;
    end
  end

  // Mid-frame entry: any edge wakes; otherwise passive-to-active only
  assign wakeEdge = busyQ ? (rxLine ^ rxPrev) : (rxLine & ~rxPrev);

  // Clock settle window
  assign stabLen  = (stabCycles == '0) ? DEF_LEN : stabCycles;
  assign stabDone = strobe.stabActive && (stabCnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    stabCnt <= '0;
    else if (strobe.wakeDeep)                     stabCnt <= stabLen;
    else if (strobe.stabActive && stabCnt != '0)  stabCnt <= stabCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 clocksReady <= 1'b1;
    else if (strobe.enterDeep) clocksReady <= 1'b0;
    else if (stabDone)         clocksReady <= 1'b1;
  end

  // Interrupts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPulse <= 1'b0;
    else       nmiPulse <= strobe.wakeDeep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              maskIrq <= 1'b0;
    else if (strobe.wakeLight && intEnable) maskIrq <= 1'b1;
    else if (intClear)                      maskIrq <= 1'b0;
  end

  // Trust flag for the frame that caused the wakeup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wakeFrameValid <= 1'b0;
    else if (strobe.wakeLight) wakeFrameValid <= 1'b1;
    else if (strobe.wakeDeep)  wakeFrameValid <= viaWaitQ && eofQ && !busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sleepRefused <= 1'b0;
    else if (strobe.refuse) sleepRefused <= 1'b1;
  end

  assert_nmi_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    nmiPulse |=> !nmiPulse);

  assert_ready_after_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clocksReady) |-> $past(strobe.stabActive));

  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (maskIrq && !intClear) |=> maskIrq);

  assert_busy_entry_invalid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wakeDeep && busyQ) |=> !wakeFrameValid);

  assert_refused_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleepRefused |=> sleepRefused);

endmodule

// File: rtl/wake_top.sv
module wake_top
  import wake_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int STAB_DEFAULT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             waitReq,
  input  logic             stopReq,
  input  logic             waitToDeep,
  input  logic             intEnable,
  input  logic             intClear,
  input  logic             rxLine,
  input  logic             frameDone,
  input  logic             eofSeen,
  input  logic             rxBusy,
  input  logic             txActive,
  input  logic [CNT_W-1:0] stabCycles,
  output logic             txEnable,
  output logic             clkStop,
  output logic             clocksReady,
  output logic             inLight,
  output logic             inDeep,
  output logic             maskIrq,
  output logic             nmiPulse,
  output logic             wakeFrameValid,
  output logic             sleepRefused
);

  wakeStrobe_t strobe;
  sleepState_t state;
  logic        wakeEdge;
  logic        stabDone;

  wake_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .waitReq    (waitReq),
    .stopReq    (stopReq),
    .waitToDeep (waitToDeep),
    .txActive   (txActive),
    .frameDone  (frameDone),
    .wakeEdge   (wakeEdge),
    .stabDone   (stabDone),
    .strobe     (strobe),
    .state      (state)
  );

  wake_datapath #(
    .CNT_W        (CNT_W),
    .STAB_DEFAULT (STAB_DEFAULT)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .rxLine         (rxLine),
    .eofSeen        (eofSeen),
    .rxBusy         (rxBusy),
    .intEnable      (intEnable),
    .intClear       (intClear),
    .stabCycles     (stabCycles),
    .wakeEdge       (wakeEdge),
    .stabDone       (stabDone),
    .clocksReady    (clocksReady),
    .maskIrq        (maskIrq),
    .nmiPulse       (nmiPulse),
    .wakeFrameValid (wakeFrameValid),
    .sleepRefused   (sleepRefused)
  );

  assign txEnable = (state == S_AWAKE);
  assign clkStop  = (state == S_DEEP);
  assign inLight  = (state == S_LIGHT);
  assign inDeep   = (state == S_DEEP);

  assert_deep_clocks_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    inDeep |-> !clocksReady);

endmodule

// File: tb/sim_wake_top.sv
module sim_wake_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic waitReq = 0, stopReq = 0, waitToDeep = 0, intEnable = 0, intClear = 0;
  logic rxLine = 0, frameDone = 0, eofSeen = 0, rxBusy = 0, txActive = 0;
  logic [CNT_W-1:0] stabCycles = 8'd3;
  logic txEnable, clkStop, clocksReady, inLight, inDeep;
  logic maskIrq, nmiPulse, wakeFrameValid, sleepRefused;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_top #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .waitReq(waitReq), .stopReq(stopReq),
    .waitToDeep(waitToDeep), .intEnable(intEnable), .intClear(intClear),
    .rxLine(rxLine), .frameDone(frameDone), .eofSeen(eofSeen), .rxBusy(rxBusy),
    .txActive(txActive), .stabCycles(stabCycles), .txEnable(txEnable),
    .clkStop(clkStop), .clocksReady(clocksReady), .inLight(inLight),
    .inDeep(inDeep), .maskIrq(maskIrq), .nmiPulse(nmiPulse),
    .wakeFrameValid(wakeFrameValid), .sleepRefused(sleepRefused)
  );

  // Deep-sleep vectors: [5]stop [4]waitToDeep [3]eof [2]busy [1]fallEdge [0]expValid
  localparam int NVEC = 7;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b0_1_1_0_0_1,  // wait path, eof seen, idle bus: valid
    6'b0_1_0_0_0_0,  // wait path, no eof: invalid
    6'b1_0_1_0_0_0,  // stop path: invalid
    6'b1_1_1_0_0_0,  // stop overrides wait config: invalid
    6'b0_1_1_1_0_0,  // entered mid-frame, rising edge: invalid
    6'b0_1_1_1_1_0,  // entered mid-frame, falling edge wakes: invalid
    6'b1_0_0_1_1_0   // stop mid-frame, falling edge wakes: invalid
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits for the settle window after a wake edge, returns its length
  task automatic settle(output int n);
    n = 0;
    while (!clocksReady && n < 300) begin
      @(posedge clk); n++; #1;
      if (n == 1) chk("R5 nmi one cycle", nmiPulse, 0);
      if (!clocksReady) chk("R6 tx held in settle", txEnable, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk("R11 txEnable", txEnable, 1);
    chk("R11 clocksReady", clocksReady, 1);
    chk("R11 maskIrq", maskIrq, 0);
    chk("R11 nmiPulse", nmiPulse, 0);
    chk("R11 valid", wakeFrameValid, 0);
    chk("R11 refused", sleepRefused, 0);
    chk("R11 sleep flags", {inLight, inDeep, clkStop}, 0);

    // Deep-sleep vector table (R2, R5, R6, R7, R8)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      waitToDeep = VEC[i][4]; eofSeen = VEC[i][3]; rxBusy = VEC[i][2]; rxLine = VEC[i][1];
      @(negedge clk);
      stopReq = VEC[i][5]; waitReq = !VEC[i][5];
      @(posedge clk); #1;
      chk("R2 deep entered", inDeep, 1);
      chk("R2 clkStop", clkStop, 1);
      chk("R2 tx gated", txEnable, 0);
      chk("R2 not ready", clocksReady, 0);
      @(negedge clk);
      stopReq = 0; waitReq = 0; eofSeen = 0; rxBusy = 0;
      repeat (2) @(negedge clk);
      chk("R2 still deep", inDeep, 1);
      rxLine = !VEC[i][1];
      @(posedge clk); #1;
      chk("R5 nmi raised", nmiPulse, 1);
      chk("R5 clkStop dropped", clkStop, 0);
      settle(n);
      chk("R6 settle length 3", n, 3);
      chk("R7 R8 valid flag", wakeFrameValid, VEC[i][0]);
      chk("R6 tx back", txEnable, 1);
    end

    // R8: falling edge without mid-frame entry does not wake
    @(negedge clk); waitToDeep = 1; rxLine = 1;
    @(negedge clk); waitReq = 1;
    @(negedge clk); waitReq = 0; rxLine = 0;
    repeat (3) @(negedge clk);
    chk("R8 falling ignored", inDeep, 1);
    chk("R8 no nmi", nmiPulse, 0);
    rxLine = 1;
    @(posedge clk); #1;
    chk("R5 rising wakes", nmiPulse, 1);
    settle(n);

    // R6 default settle length with stabCycles = 0
    @(negedge clk); stabCycles = 0; rxLine = 0;
    @(negedge clk); stopReq = 1;
    @(negedge clk); stopReq = 0;
    @(negedge clk); rxLine = 1;
    @(posedge clk); #1;
    settle(n);
    chk("R6 default settle 64", n, 64);
    stabCycles = 8'd3;

    // Light sleep with interrupt enabled (R1, R3, R4, R10)
    @(negedge clk); waitToDeep = 0; intEnable = 1; rxLine = 0; waitReq = 1;
    @(posedge clk); #1;
    chk("R1 light entered", inLight, 1);
    chk("R1 clocks on", clkStop, 0);
    chk("R1 tx gated", txEnable, 0);
    @(negedge clk); waitReq = 0; rxLine = 1;
    @(negedge clk); rxLine = 0;
    @(negedge clk);
    chk("R4 edges ignored", inLight, 1);
    chk("R4 no nmi", nmiPulse, 0);
    frameDone = 1;
    @(posedge clk); #1;
    chk("R3 awake", inLight, 0);
    chk("R3 maskIrq set", maskIrq, 1);
    chk("R3 valid", wakeFrameValid, 1);
    chk("R3 tx back", txEnable, 1);
    @(negedge clk); frameDone = 0;
    repeat (3) @(negedge clk);
    chk("R10 irq held", maskIrq, 1);
    intClear = 1;
    @(posedge clk); #1;
    chk("R10 irq cleared", maskIrq, 0);
    @(negedge clk); intClear = 0;

    // R3 light sleep with interrupt disabled; previous deep wake left valid = 0
    @(negedge clk); waitToDeep = 1; waitReq = 1;
    @(negedge clk); waitReq = 0; rxLine = 1;
    @(posedge clk); #1; settle(n);
    chk("R7 stop-less wait no eof invalid", wakeFrameValid, 0);
    @(negedge clk); waitToDeep = 0; intEnable = 0; waitReq = 1;
    @(negedge clk); waitReq = 0; frameDone = 1;
    @(posedge clk); #1;
    chk("R3 no irq when disabled", maskIrq, 0);
    chk("R3 valid after light", wakeFrameValid, 1);
    @(negedge clk); frameDone = 0;

    // R9 refusal while transmitting
    @(negedge clk); txActive = 1; stopReq = 1;
    @(posedge clk); #1;
    chk("R9 stays awake", inDeep, 0);
    chk("R9 tx enabled", txEnable, 1);
    chk("R9 refused flag", sleepRefused, 1);
    @(negedge clk); stopReq = 0; txActive = 0;
    @(negedge clk); waitReq = 1;
    @(posedge clk); #1;
    chk("R9 later request accepted", inLight, 1);
    chk("R9 flag sticky", sleepRefused, 1);
    @(negedge clk); waitReq = 0; frameDone = 1;
    @(negedge clk); frameDone = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule